// File: doc/BRIEF.md
# Low-Power Compare Timer

This peripheral counts slow timer-clock ticks in a 24-bit up-counter and flags a compare match, so that a system can be woken or interrupted after a programmed number of ticks. Software on a fast bus clock programs it through four word registers: control, compare, counter readback and status. The counter lives entirely in the timer clock domain. A prescaler divides the timer clock by a programmable value from 1 to 128 before each count step.

Counting is continuous. A compare match raises an interrupt flag and a wakeup flag, but the counter carries on past the match and wraps at the top of its range. The compare value can be rewritten while the counter runs without upsetting the count. A stop followed by a restart begins again from zero. Bus writes to control and compare reach the timer domain through a toggle handshake and land within three timer clocks. The counter is read back through a Gray-coded copy, so a read never returns a torn value.

The timer domain is run by a three-state machine. In `T_IDLE` the counter holds its value. `T_ARM` is one cycle that clears the counter and prescaler. `T_RUN` counts. The transitions are: IDLE→ARM when the captured run bit is 1; ARM→RUN when run is still 1, otherwise ARM→IDLE; RUN→IDLE when run drops to 0; RUN→RUN while run stays 1.

Top module: `lpt_timer`

Register map (word address on `bus_addr`): 0 = control, 1 = compare, 2 = counter (read-only), 3 = status.
Control bits: [0] run, [1] interrupt enable, [2] wakeup enable, [3] active status (read-only), [14:8] prescale.
Status bits: [0] interrupt flag, [1] wakeup flag.

## Requirements
- R1: After reset, control reads 0, compare reads 0xFFFFFF, counter reads 0, status reads 0, and `irq` and `wake` are low.
- R2: While running, the counter advances by one every prescale+1 timer clocks (prescale in control bits [14:8]).
- R3: A compare match does not clear the counter. Each step is +1, and the count wraps from 0xFFFFFF to 0.
- R4: Writing the compare register (address 1) while running leaves the count undisturbed.
- R5: While stopped the counter holds its value. A restart (control bit 0 written 1 again) begins counting from 0.
- R6: A compare write of 0 or 1 is stored as 2 and reads back as 2, and the match then occurs when the count reaches 2.
- R7: A control write takes effect in the timer domain within 3 timer clocks. The active bit (control bit 3) reads 1 no later than 6 timer clocks plus 4 bus clocks after a start write.
- R8: The active bit is 0 until the counter is really counting, and returns to 0 after a stop.
- R9: The step onto the compare value sets both status bit 0 (interrupt flag) and status bit 1 (wakeup flag). Writing 1 to a status bit clears only that bit.
- R10: `irq` equals status bit 0 AND control bit 1; `wake` equals status bit 1 AND control bit 2.
- R11: Counter readback is coherent. Back-to-back reads while counting at prescale 0 differ by 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Bus (programming) clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| tmr_clk | input | 1 | Slow timer clock |
| tmr_rst_n | input | 1 | Active-low reset, timer domain |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe, sampled on bus_clk |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Gated compare-match interrupt |
| wake | output | 1 | Gated compare-match wakeup |

## Verification
Some properties are checked on every cycle by assertions:
- each running count step is either a hold or +1, including the wrap;
- the arm state leaves the counter at zero;
- an idle counter stays still;
- the stored compare value never falls below 2;
- a match pulse always sets both flags;
- a write-one clear removes the interrupt flag.

The bench scenarios show the rest, which cross both clock domains:
- the prescale ratio measured over many ticks;
- the latency of the active bit;
- that a live compare write leaves the count alone;
- the restart from zero;
- the clamped match at count 2;
- the enable gating of `irq` and `wake`;
- the absence of torn values across long runs of back-to-back counter reads.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    // timer-domain sequencing
    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_ARM  = 2'd1,
        T_RUN  = 2'd2
    } tmr_state_e;

    // register word addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    // control bit positions
    localparam int CB_RUN    = 0;
    localparam int CB_IE     = 1;
    localparam int CB_WE     = 2;
    localparam int CB_ACT    = 3;
    localparam int CB_PRE_LO = 8;

    // status bit positions
    localparam int SB_INT  = 0;
    localparam int SB_WAKE = 1;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/lpt_core.sv
module lpt_core
    import lpt_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int PRE_W   = 7,
    parameter int CMP_MIN = 2
) (
    input  logic             tclk,
    input  logic             trst_n,
    input  logic             req_tgl,
    input  logic             sh_run,
    input  logic [PRE_W-1:0] sh_presc,
    input  logic [CNT_W-1:0] sh_cmp,
    output logic             active,
    output logic             match_tgl,
    output logic [CNT_W-1:0] cnt_gray
);

    localparam logic [CNT_W-1:0] CMP_RST = {CNT_W{1'b1}};

    tmr_state_e       state, state_n;
    logic             req_s, req_d, load;
    logic             run_q;
    logic [PRE_W-1:0] presc_q, pre_cnt;
    logic [CNT_W-1:0] cmp_q, cnt, cnt_inc;

    // request toggle crossing from the bus domain
    lpt_sync #(.W(1), .STAGES(2)) u_req_sync (
        .clk  (tclk),
        .rst_n(trst_n),
        .d    (req_tgl),
        .q    (req_s)
    );

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) req_d <= 1'b0;
        else         req_d <= req_s;
    end

    assign load = req_s ^ req_d;

    // capture of the bus shadows; they are held steady while the toggle crosses
    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            run_q   <= 1'b0;
            presc_q <= '0;
            cmp_q   <= CMP_RST;
        end else if (load) begin
            run_q   <= sh_run;
            presc_q <= sh_presc;
            cmp_q   <= sh_cmp;
        end
    end

    // state register
    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) state <= T_IDLE;
        else         state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            T_IDLE:  state_n = run_q ? T_ARM : T_IDLE;
            T_ARM:   state_n = run_q ? T_RUN : T_IDLE;
            T_RUN:   state_n = run_q ? T_RUN : T_IDLE;
            default: state_n = T_IDLE;
        endcase
    end

    assign cnt_inc = cnt + 1'b1;

    // per-state outputs: prescaler, counter, match toggle
    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            cnt       <= '0;
            pre_cnt   <= '0;
            match_tgl <= 1'b0;
        end else begin
            unique case (state)
                T_ARM: begin
                    cnt     <= '0;
                    pre_cnt <= '0;
                end
                T_RUN: begin
                    if (pre_cnt == presc_q) begin
                        pre_cnt <= '0;
                        cnt     <= cnt_inc;
                        if (cnt_inc == cmp_q) match_tgl <= ~match_tgl;
                    end else begin
                        pre_cnt <= pre_cnt + 1'b1;
                    end
                end
                default: begin
                    cnt     <= cnt;
                    pre_cnt <= pre_cnt;
                end
            endcase
        end
    end

    // one-bit-per-step copy for the bus-side readback
    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) cnt_gray <= '0;
        else         cnt_gray <= CNT_W'(bin2gray(32'(cnt)));
    end

    assign active = (state == T_RUN);

    // R3: a running step is either a hold or +1, wrap included
    p_step_or_hold_r3: assert property (@(posedge tclk) disable iff (!trst_n)
        (state == T_RUN && $past(state) == T_RUN)
            |-> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    // R5: arming leaves the counter at zero
    p_arm_zero_r5: assert property (@(posedge tclk) disable iff (!trst_n)
        (state == T_ARM) |=> (cnt == '0));

    // R5: an idle counter does not move
    p_idle_hold_r5: assert property (@(posedge tclk) disable iff (!trst_n)
        (state == T_IDLE) |=> $stable(cnt));

    // R6: the captured compare value is never below the floor
    p_cmp_floor_r6: assert property (@(posedge tclk) disable iff (!trst_n)
        cmp_q >= CNT_W'(CMP_MIN));

endmodule

// File: rtl/lpt_bus_regs.sv
module lpt_bus_regs
    import lpt_pkg::*;
#(
    parameter int CNT_W   = 24,
    parameter int PRE_W   = 7,
    parameter int DATA_W  = 32,
    parameter int CMP_MIN = 2
) (
    input  logic              bclk,
    input  logic              brst_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wake,
    input  logic              active_t,
    input  logic              match_tgl_t,
    input  logic [CNT_W-1:0]  cnt_gray_t,
    output logic              req_tgl,
    output logic              sh_run,
    output logic [PRE_W-1:0]  sh_presc,
    output logic [CNT_W-1:0]  sh_cmp
);

    localparam logic [CNT_W-1:0] CMP_RST   = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CMP_FLOOR = CNT_W'(CMP_MIN);

    logic             ie, we;
    logic             act_s, m_s, m_d, match_set;
    logic             int_flag, wake_flag;
    logic [CNT_W-1:0] gray_s, cnt_bin, cmp_wv;
    logic             wr_ctrl, wr_cmp, wr_stat;

    lpt_sync #(.W(1), .STAGES(2)) u_act_sync (
        .clk(bclk), .rst_n(brst_n), .d(active_t), .q(act_s)
    );

    lpt_sync #(.W(1), .STAGES(2)) u_match_sync (
        .clk(bclk), .rst_n(brst_n), .d(match_tgl_t), .q(m_s)
    );

    lpt_sync #(.W(CNT_W), .STAGES(2)) u_cnt_sync (
        .clk(bclk), .rst_n(brst_n), .d(cnt_gray_t), .q(gray_s)
    );

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) m_d <= 1'b0;
        else         m_d <= m_s;
    end

    assign match_set = m_s ^ m_d;
    assign cnt_bin   = CNT_W'(gray2bin(32'(gray_s)));

    assign wr_ctrl = wr && (addr == ADDR_CTRL);
    assign wr_cmp  = wr && (addr == ADDR_CMP);
    assign wr_stat = wr && (addr == ADDR_STAT);
    assign cmp_wv  = wdata[CNT_W-1:0];

    // shadow registers and request toggle
    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            sh_run   <= 1'b0;
            ie       <= 1'b0;
            we       <= 1'b0;
            sh_presc <= '0;
            sh_cmp   <= CMP_RST;
            req_tgl  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                sh_run   <= wdata[CB_RUN];
                ie       <= wdata[CB_IE];
                we       <= wdata[CB_WE];
                sh_presc <= wdata[CB_PRE_LO +: PRE_W];
            end
            if (wr_cmp) begin
                sh_cmp <= (cmp_wv < CMP_FLOOR) ? CMP_FLOOR : cmp_wv;
            end
            if (wr_ctrl || wr_cmp) req_tgl <= ~req_tgl;
        end
    end

    // flags: a match wins over a simultaneous clear
    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) begin
            int_flag  <= 1'b0;
            wake_flag <= 1'b0;
        end else begin
            int_flag  <= match_set | (int_flag  & ~(wr_stat & wdata[SB_INT]));
            wake_flag <= match_set | (wake_flag & ~(wr_stat & wdata[SB_WAKE]));
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_CTRL: begin
                rdata[CB_RUN]              = sh_run;
                rdata[CB_IE]               = ie;
                rdata[CB_WE]               = we;
                rdata[CB_ACT]              = act_s;
                rdata[CB_PRE_LO +: PRE_W]  = sh_presc;
            end
            ADDR_CMP:  rdata[CNT_W-1:0] = sh_cmp;
            ADDR_CNT:  rdata[CNT_W-1:0] = cnt_bin;
            ADDR_STAT: begin
                rdata[SB_INT]  = int_flag;
                rdata[SB_WAKE] = wake_flag;
            end
            default:   rdata = '0;
        endcase
    end

    assign irq  = int_flag  & ie;
    assign wake = wake_flag & we;

    // R9: a match event sets both flags
    p_match_sets_r9: assert property (@(posedge bclk) disable iff (!brst_n)
        match_set |=> (int_flag && wake_flag));

    // R9: write-one clears the interrupt flag when no match arrives
    p_w1c_int_r9: assert property (@(posedge bclk) disable iff (!brst_n)
        (wr_stat && wdata[SB_INT] && !match_set) |=> !int_flag);

    // R6: the stored compare shadow never falls below the floor
    p_shadow_floor_r6: assert property (@(posedge bclk) disable iff (!brst_n)
        sh_cmp >= CMP_FLOOR);

endmodule

// File: rtl/lpt_timer.sv
module lpt_timer #(
    parameter int CNT_W   = 24,
    parameter int PRE_W   = 7,
    parameter int DATA_W  = 32,
    parameter int CMP_MIN = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              tmr_clk,
    input  logic              tmr_rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              wake
);

    logic             active_t, match_tgl_t, req_tgl, sh_run;
    logic [CNT_W-1:0] cnt_gray_t, sh_cmp;
    logic [PRE_W-1:0] sh_presc;

    lpt_bus_regs #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W), .CMP_MIN(CMP_MIN)
    ) u_regs (
        .bclk       (bus_clk),
        .brst_n     (bus_rst_n),
        .addr       (bus_addr),
        .wr         (bus_wr),
        .wdata      (bus_wdata),
        .rdata      (bus_rdata),
        .irq        (irq),
        .wake       (wake),
        .active_t   (active_t),
        .match_tgl_t(match_tgl_t),
        .cnt_gray_t (cnt_gray_t),
        .req_tgl    (req_tgl),
        .sh_run     (sh_run),
        .sh_presc   (sh_presc),
        .sh_cmp     (sh_cmp)
    );

    lpt_core #(
        .CNT_W(CNT_W), .PRE_W(PRE_W), .CMP_MIN(CMP_MIN)
    ) u_core (
        .tclk     (tmr_clk),
        .trst_n   (tmr_rst_n),
        .req_tgl  (req_tgl),
        .sh_run   (sh_run),
        .sh_presc (sh_presc),
        .sh_cmp   (sh_cmp),
        .active   (active_t),
        .match_tgl(match_tgl_t),
        .cnt_gray (cnt_gray_t)
    );

endmodule

// File: tb/lpt_timer_tb_top.sv
`timescale 1ns/1ps
module lpt_timer_tb_top;

    logic        bus_clk = 1'b0, tmr_clk = 1'b0;
    logic        bus_rst_n = 1'b0, tmr_rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [31:0] RUN = 32'h1, IE = 32'h2, WE = 32'h4;

    always #10 bus_clk = ~bus_clk;
    always #68 tmr_clk = ~tmr_clk;

    lpt_timer dut_i (
        .bus_clk(bus_clk), .bus_rst_n(bus_rst_n),
        .tmr_clk(tmr_clk), .tmr_rst_n(tmr_rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
    );

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input logic [31:0] act,
                           input logic [31:0] lo, input logic [31:0] hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge bus_clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic wait_t(input int n);
        repeat (n) @(posedge tmr_clk);
        repeat (4) @(negedge bus_clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bus_read(2'd0, d); chk_eq("R1 ctrl", d, 32'h0);
        bus_read(2'd1, d); chk_eq("R1 cmp", d, 32'hFF_FFFF);
        bus_read(2'd2, d); chk_eq("R1 cnt", d, 32'h0);
        bus_read(2'd3, d); chk_eq("R1 stat", d, 32'h0);
        chk_eq("R1 irq/wake", {30'd0, irq, wake}, 32'h0);
    endtask

    task automatic t_active_latency();
        logic [31:0] d;
        bus_write(2'd0, RUN | IE | WE);
        bus_read(2'd0, d); chk_eq("R8 active low before counting", {31'd0, d[3]}, 32'h0);
        wait_t(6);
        bus_read(2'd0, d); chk_eq("R7 active within latency", {31'd0, d[3]}, 32'h1);
    endtask

    task automatic t_coherent();
        logic [31:0] a, b;
        int bad = 0;
        bus_read(2'd2, a);
        for (int i = 0; i < 300; i++) begin
            bus_read(2'd2, b);
            if (((b - a) & 32'hFF_FFFF) > 1) bad++;
            a = b;
        end
        chk_eq("R11 torn or jumping reads", bad, 0);
    endtask

    task automatic t_cmp_live();
        logic [31:0] a, b;
        bus_read(2'd2, a);
        bus_write(2'd1, a + 32'd5000);
        bus_read(2'd2, b);
        chk_rng("R4 count across live compare write", b - a, 0, 3);
        wait_t(10);
        bus_read(2'd2, b);
        chk_rng("R4 count keeps stepping", b - a, 8, 16);
    endtask

    task automatic t_prescale();
        logic [31:0] a, b;
        bus_write(2'd0, RUN | IE | WE | (32'd3 << 8));
        wait_t(10);
        bus_read(2'd2, a);
        wait_t(80);
        bus_read(2'd2, b);
        chk_rng("R2 divide by 4 over 80 clocks", b - a, 19, 21);
    endtask

    task automatic t_restart_zero();
        logic [31:0] a, b;
        bus_write(2'd0, IE | WE);
        wait_t(6);
        bus_read(2'd0, a); chk_eq("R8 active low after stop", {31'd0, a[3]}, 32'h0);
        bus_read(2'd2, a);
        wait_t(10);
        bus_read(2'd2, b); chk_eq("R5 count held while stopped", b, a);
        bus_write(2'd1, 32'd20);
        bus_write(2'd3, 32'h3);
        bus_write(2'd0, RUN | IE | WE);
        wait_t(6);
        bus_read(2'd2, b); chk_rng("R5 restart from zero", b, 0, 4);
    endtask

    task automatic t_match_flags();
        logic [31:0] d;
        wait_t(40);
        bus_read(2'd3, d); chk_eq("R9 both flags on match", d, 32'h3);
        chk_eq("R10 irq and wake asserted", {30'd0, irq, wake}, 32'h3);
        bus_read(2'd2, d); chk_rng("R3 count not cleared by match", d, 30, 60);
        bus_write(2'd3, 32'h1);
        bus_read(2'd3, d); chk_eq("R9 clear int only", d, 32'h2);
        chk_eq("R10 irq low wake high", {30'd0, irq, wake}, 32'h1);
        bus_write(2'd0, RUN | IE);
        bus_read(2'd3, d); chk_eq("R10 flag kept when wake disabled", d, 32'h2);
        chk_eq("R10 wake gated off", {31'd0, wake}, 32'h0);
        bus_write(2'd3, 32'h2);
        bus_read(2'd3, d); chk_eq("R9 clear wake", d, 32'h0);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        bus_write(2'd0, IE | WE);
        wait_t(4);
        bus_write(2'd1, 32'd0);
        bus_read(2'd1, d); chk_eq("R6 compare 0 stored as 2", d, 32'd2);
        bus_write(2'd1, 32'd1);
        bus_read(2'd1, d); chk_eq("R6 compare 1 stored as 2", d, 32'd2);
        bus_write(2'd3, 32'h3);
        bus_read(2'd3, d); chk_eq("R6 status clear before run", d, 32'h0);
        bus_write(2'd0, RUN | IE | WE);
        wait_t(10);
        bus_read(2'd3, d); chk_eq("R6 match at clamped compare", d, 32'h3);
        chk_eq("R6 irq raised", {31'd0, irq}, 32'h1);
        bus_read(2'd2, d); chk_rng("R6 count past 2", d, 2, 14);
    endtask

    initial begin
        repeat (3) @(posedge tmr_clk);
        @(negedge bus_clk);
        bus_rst_n = 1'b1;
        tmr_rst_n = 1'b1;
        repeat (2) @(posedge tmr_clk);
        t_reset_state();
        t_active_latency();
        t_coherent();
        t_cmp_live();
        t_prescale();
        t_restart_zero();
        t_match_flags();
        t_clamp();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bus_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..all actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule